// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date in seven packed-BCD registers. A free-running prescaler counts enables from a 32.768 kHz time base. Every `DIV` enables it issues one second step. A small sequencer then walks the carry through the registers, one register per clock cycle: seconds, minutes, hours, then day-of-week and date together, then month and year. The hours register holds a format bit and selects either a 24-hour count or a 12-hour count with an AM/PM flag. Month lengths and the two-digit leap-year rule are applied automatically in BCD.

A bus front end presets or reads the time through a byte-wide register port. A write to the seconds register restarts the prescaler, so the first step after a preset comes one full second later. Bit 7 of the seconds register halts counting. The block leaves reset halted at a defined time, and software is expected to write every register before it clears the halt bit.

Sequencer states: `ST_IDLE` waits for a second step. `ST_SEC`, `ST_MIN`, `ST_HOUR`, `ST_DAY`, `ST_MONTH` and `ST_YEAR` each update their own register in the cycle they are active.

Transitions:
- `ST_IDLE` to `ST_SEC` on a second step.
- Each state moves to the next state in the chain when its register wraps, and returns to `ST_IDLE` otherwise.
- `ST_YEAR` always returns to `ST_IDLE`.
- Any register write made while the sequencer is outside `ST_IDLE` returns it to `ST_IDLE`.

Top module: `bcd_clock_calendar`

## Requirements
- R1: The register map is address 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, all packed BCD. Unused bits read 0: minutes bit 7, hours bit 7, day-of-week bits 7:3, date bits 7:6 and month bits 7:5. Address 7 reads 0 and ignores writes.
- R2: Seconds bit 7 set to 1 halts counting, so all registers hold. Set to 0, the clock runs.
- R3: Seconds and minutes count 00 to 59. The step from 59 gives 00 and carries into the next register.
- R4: With hours bit 6 = 0 (24-hour), hours bits 5:0 count 00 to 23 in BCD, with bit 5 acting as the tens-of-hours "2" bit. The step from 23 gives 00 and advances the day.
- R5: With hours bit 6 = 1 (12-hour), bits 4:0 count 12, 01 … 11 and bit 5 = 1 means PM. The step from 11 to 12 toggles bit 5. Only the step from 11 PM to 12 AM advances the day.
- R6: The last date is 30 in April, June, September and November, and 31 in the other months except February. After the last date comes 01 with a month carry.
- R7: February ends on 29 when the BCD year is divisible by 4 (00 included) and on 28 otherwise.
- R8: Day of week counts 1 to 7, advances with the date, and goes from 7 to 1.
- R9: Month goes from 12 to 01 with a year carry. Year goes from 99 to 00.
- R10: A second step occurs every `DIV` time-base enables. A write to seconds clears the prescaler, so the next step comes `DIV` enables after the write.
- R11: After reset, seconds reads 0x80 (halted), day of week, date and month read 01, and the other registers read 00.
- R12: A register write made while the carry sequencer is outside `ST_IDLE` ends the carry chain, and the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_tick | input | 1 | One-cycle enable at the 32.768 kHz time-base rate |
| reg_addr | input | 3 | Register address for read and write |
| reg_wr | input | 1 | Write strobe; `reg_wdata` is stored at `reg_addr` on the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data of the register at `reg_addr` |

## Verification
The counting function is driven from preset times chosen so that one second step exercises a single carry depth. These run from a plain seconds increment, through a minute carry, up to a full year rollover, which separates faults in each link of the chain. Hours are tried in both formats at the AM-to-PM, PM-to-AM, 12-to-1 and 19-to-20 edges, which isolates the PM toggle from the day carry. Month-end dates over 30-day, 31-day and February months, with leap and non-leap years of both even and odd tens digits, separate the month-length table from the leap test. Timed writes check the halt bit, the prescaler clear and the abort of a carry chain in flight.

// File: rtl/bcdc_pkg.sv
package bcdc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SEC   = 3'd1,
        ST_MIN   = 3'd2,
        ST_HOUR  = 3'd3,
        ST_DAY   = 3'd4,
        ST_MONTH = 3'd5,
        ST_YEAR  = 3'd6
    } step_t;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_SEC   = 3'd0;
    localparam logic [ADDR_W-1:0] A_MIN   = 3'd1;
    localparam logic [ADDR_W-1:0] A_HOUR  = 3'd2;
    localparam logic [ADDR_W-1:0] A_DOW   = 3'd3;
    localparam logic [ADDR_W-1:0] A_DATE  = 3'd4;
    localparam logic [ADDR_W-1:0] A_MONTH = 3'd5;
    localparam logic [ADDR_W-1:0] A_YEAR  = 3'd6;

    // Packed-BCD increment of a two-digit byte (no upper limit applied).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) begin
            return {v[7:4] + 4'd1, 4'd0};
        end
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/bcdc_prescaler.sv
module bcdc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic base_tick,
    input  logic clr,
    output logic sec_pulse
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (run && base_tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign sec_pulse = run && base_tick && !clr && (cnt_q == LAST);

    // R10: a seconds write restarts the divider from zero
    p_clear_restarts_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    // R2: with the clock halted the divider does not move
    p_halt_holds_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/bcdc_hour_step.sv
module bcdc_hour_step (
    input  logic [7:0] hr_in,
    output logic [7:0] hr_out,
    output logic       day_carry
);
    logic       pm;
    logic [4:0] h12;
    logic [5:0] h24;

    always_comb begin
        pm        = hr_in[5];
        h12       = hr_in[4:0];
        h24       = hr_in[5:0];
        hr_out    = hr_in;
        day_carry = 1'b0;
        if (hr_in[7]) begin
            // bit 7 is always stored as zero; keep value unchanged
            hr_out = hr_in;
        end else if (hr_in[6]) begin
            if (h12 == 5'h11) begin
                hr_out    = {2'b01, ~pm, 5'h12};
                day_carry = pm;
            end else if (h12 == 5'h12) begin
                hr_out = {2'b01, pm, 5'h01};
            end else if (h12[3:0] == 4'd9) begin
                hr_out = {2'b01, pm, 5'h10};
            end else begin
                hr_out = {2'b01, pm, h12[4], h12[3:0] + 4'd1};
            end
        end else begin
            if (h24 == 6'h23) begin
                hr_out    = 8'h00;
                day_carry = 1'b1;
            end else if (h24[3:0] == 4'd9) begin
                hr_out = {2'b00, h24[5:4] + 2'd1, 4'd0};
            end else begin
                hr_out = {2'b00, h24[5:4], h24[3:0] + 4'd1};
            end
        end
    end

endmodule

// File: rtl/bcdc_month_days.sv
module bcdc_month_days (
    input  logic [7:0] month,
    input  logic [7:0] year,
    output logic [7:0] last_date
);
    logic [5:0] mod_sum;
    logic       leap;

    // 10*t + o is divisible by 4 exactly when 2*t + o is
    always_comb begin
        mod_sum = {1'b0, year[7:4], 1'b0} + {2'b00, year[3:0]};
        leap    = (mod_sum[1:0] == 2'b00);
        unique case (month)
            8'h02:                      last_date = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
            default:                    last_date = 8'h31;
        endcase
    end

endmodule

// File: rtl/bcd_clock_calendar.sv
module bcd_clock_calendar
    import bcdc_pkg::*;
#(
    parameter int DIV = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_tick,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata
);
    step_t      state_q, state_d;
    logic [7:0] sec_q, min_q, hr_q, dow_q, date_q, mon_q, yr_q;
    logic       sec_pulse;
    logic       wr_sec;
    logic [7:0] hr_next;
    logic       hr_carry;
    logic [7:0] last_date;

    assign wr_sec = reg_wr && (reg_addr == A_SEC);

    bcdc_prescaler #(.DIV(DIV)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (!sec_q[7]),
        .base_tick (base_tick),
        .clr       (wr_sec),
        .sec_pulse (sec_pulse)
    );

    bcdc_hour_step u_hour (
        .hr_in     (hr_q),
        .hr_out    (hr_next),
        .day_carry (hr_carry)
    );

    bcdc_month_days u_mdays (
        .month     (mon_q),
        .year      (yr_q),
        .last_date (last_date)
    );

    // Sequencer state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Sequencer next state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE:  state_d = sec_pulse ? ST_SEC : ST_IDLE;
            ST_SEC:   state_d = (sec_q[6:0] == 7'h59) ? ST_MIN : ST_IDLE;
            ST_MIN:   state_d = (min_q == 8'h59) ? ST_HOUR : ST_IDLE;
            ST_HOUR:  state_d = hr_carry ? ST_DAY : ST_IDLE;
            ST_DAY:   state_d = (date_q >= last_date) ? ST_MONTH : ST_IDLE;
            ST_MONTH: state_d = (mon_q == 8'h12) ? ST_YEAR : ST_IDLE;
            ST_YEAR:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (reg_wr && (state_q != ST_IDLE)) begin
            state_d = ST_IDLE;
        end
    end

    // Register file: a write wins over the step of the active state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= 8'h80;
            min_q  <= 8'h00;
            hr_q   <= 8'h00;
            dow_q  <= 8'h01;
            date_q <= 8'h01;
            mon_q  <= 8'h01;
            yr_q   <= 8'h00;
        end else begin
            if (wr_sec) begin
                sec_q <= reg_wdata;
            end else if (state_q == ST_SEC) begin
                sec_q <= (sec_q[6:0] == 7'h59) ? {sec_q[7], 7'h00}
                       : (bcd_inc({1'b0, sec_q[6:0]}) | {sec_q[7], 7'h00});
            end

            if (reg_wr && reg_addr == A_MIN) begin
                min_q <= {1'b0, reg_wdata[6:0]};
            end else if (state_q == ST_MIN) begin
                min_q <= (min_q == 8'h59) ? 8'h00 : bcd_inc(min_q);
            end

            if (reg_wr && reg_addr == A_HOUR) begin
                hr_q <= {1'b0, reg_wdata[6:0]};
            end else if (state_q == ST_HOUR) begin
                hr_q <= hr_next;
            end

            if (reg_wr && reg_addr == A_DOW) begin
                dow_q <= {5'b0, reg_wdata[2:0]};
            end else if (state_q == ST_DAY) begin
                dow_q <= (dow_q >= 8'h07) ? 8'h01 : dow_q + 8'h01;
            end

            if (reg_wr && reg_addr == A_DATE) begin
                date_q <= {2'b0, reg_wdata[5:0]};
            end else if (state_q == ST_DAY) begin
                date_q <= (date_q >= last_date) ? 8'h01 : bcd_inc(date_q);
            end

            if (reg_wr && reg_addr == A_MONTH) begin
                mon_q <= {3'b0, reg_wdata[4:0]};
            end else if (state_q == ST_MONTH) begin
                mon_q <= (mon_q == 8'h12) ? 8'h01 : bcd_inc(mon_q);
            end

            if (reg_wr && reg_addr == A_YEAR) begin
                yr_q <= reg_wdata;
            end else if (state_q == ST_YEAR) begin
                yr_q <= (yr_q == 8'h99) ? 8'h00 : bcd_inc(yr_q);
            end
        end
    end

    // Read port
    always_comb begin
        case (reg_addr)
            A_SEC:   reg_rdata = sec_q;
            A_MIN:   reg_rdata = min_q;
            A_HOUR:  reg_rdata = hr_q;
            A_DOW:   reg_rdata = dow_q;
            A_DATE:  reg_rdata = date_q;
            A_MONTH: reg_rdata = mon_q;
            A_YEAR:  reg_rdata = yr_q;
            default: reg_rdata = 8'h00;
        endcase
    end

    // R2: halted seconds stay put unless written
    p_halt_freezes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q[7] && !reg_wr) |=> $stable(sec_q));

    // R3: seconds 59 steps to 00
    p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEC && sec_q[6:0] == 7'h59 && !reg_wr) |=> (sec_q[6:0] == 7'h00));

    // R8: day of week 7 steps to 1
    p_dow_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DAY && dow_q == 8'h07 && !reg_wr) |=> (dow_q == 8'h01));

    // R9: year 99 steps to 00
    p_year_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_YEAR && yr_q == 8'h99 && !reg_wr) |=> (yr_q == 8'h00));

    // R12: a write during a carry chain returns the sequencer to idle
    p_write_ends_chain_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && state_q != ST_IDLE) |=> (state_q == ST_IDLE));

endmodule

// File: tb/bcd_clock_calendar_tb.sv
`timescale 1ns/1ps
module bcd_clock_calendar_tb;
    localparam int DIV = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b1;
    logic [2:0] reg_addr = 3'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bcd_clock_calendar #(.DIV(DIV)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: addr %0d got %02h expected %02h", req, a, reg_rdata, exp);
        end
    endtask

    // Halt, preset all registers, then release with the seconds write last
    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                            input logic [7:0] y);
        wr(3'd0, 8'h80);
        wr(3'd1, m);
        wr(3'd2, h);
        wr(3'd3, w);
        wr(3'd4, d);
        wr(3'd5, mo);
        wr(3'd6, y);
        wr(3'd0, s);
    endtask

    task automatic wait_secs(input int n);
        repeat (DIV * n + 10) @(negedge clk);
    endtask

    task automatic t_reset();
        expect_reg("R11", 3'd0, 8'h80);
        expect_reg("R11", 3'd1, 8'h00);
        expect_reg("R11", 3'd2, 8'h00);
        expect_reg("R11", 3'd3, 8'h01);
        expect_reg("R11", 3'd4, 8'h01);
        expect_reg("R11", 3'd5, 8'h01);
        expect_reg("R11", 3'd6, 8'h00);
    endtask

    task automatic t_count();
        set_time(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h20);
        wait_secs(3);
        expect_reg("R3", 3'd0, 8'h13);
        set_time(8'h58, 8'h09, 8'h00, 8'h01, 8'h01, 8'h01, 8'h20);
        wait_secs(2);
        expect_reg("R3", 3'd0, 8'h00);
        expect_reg("R3", 3'd1, 8'h10);
    endtask

    task automatic t_full_rollover();
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        wait_secs(1);
        expect_reg("R3", 3'd0, 8'h00);
        expect_reg("R3", 3'd1, 8'h00);
        expect_reg("R4", 3'd2, 8'h00);
        expect_reg("R8", 3'd3, 8'h01);
        expect_reg("R6", 3'd4, 8'h01);
        expect_reg("R9", 3'd5, 8'h01);
        expect_reg("R9", 3'd6, 8'h00);
    endtask

    task automatic t_24h_tens();
        set_time(8'h59, 8'h59, 8'h19, 8'h02, 8'h10, 8'h03, 8'h21);
        wait_secs(1);
        expect_reg("R4", 3'd2, 8'h20);
        expect_reg("R4", 3'd4, 8'h10);
        set_time(8'h59, 8'h59, 8'h09, 8'h02, 8'h10, 8'h03, 8'h21);
        wait_secs(1);
        expect_reg("R4", 3'd2, 8'h10);
    endtask

    task automatic t_12h();
        set_time(8'h59, 8'h59, 8'h71, 8'h03, 8'h15, 8'h06, 8'h24);
        wait_secs(1);
        expect_reg("R5", 3'd2, 8'h52);
        expect_reg("R5", 3'd4, 8'h16);
        expect_reg("R8", 3'd3, 8'h04);
        set_time(8'h59, 8'h59, 8'h51, 8'h03, 8'h15, 8'h06, 8'h24);
        wait_secs(1);
        expect_reg("R5", 3'd2, 8'h72);
        expect_reg("R5", 3'd4, 8'h15);
        set_time(8'h59, 8'h59, 8'h72, 8'h03, 8'h15, 8'h06, 8'h24);
        wait_secs(1);
        expect_reg("R5", 3'd2, 8'h61);
        set_time(8'h59, 8'h59, 8'h52, 8'h03, 8'h15, 8'h06, 8'h24);
        wait_secs(1);
        expect_reg("R5", 3'd2, 8'h41);
        set_time(8'h59, 8'h59, 8'h49, 8'h03, 8'h15, 8'h06, 8'h24);
        wait_secs(1);
        expect_reg("R5", 3'd2, 8'h50);
    endtask

    task automatic month_end(input string req, input logic [7:0] d, input logic [7:0] mo,
                             input logic [7:0] y, input logic [7:0] exp_d,
                             input logic [7:0] exp_mo);
        set_time(8'h59, 8'h59, 8'h23, 8'h01, d, mo, y);
        wait_secs(1);
        expect_reg(req, 3'd4, exp_d);
        expect_reg(req, 3'd5, exp_mo);
    endtask

    task automatic t_month_len();
        month_end("R6", 8'h30, 8'h04, 8'h22, 8'h01, 8'h05);
        month_end("R6", 8'h30, 8'h11, 8'h22, 8'h01, 8'h12);
        month_end("R6", 8'h30, 8'h01, 8'h22, 8'h31, 8'h01);
        month_end("R6", 8'h31, 8'h07, 8'h22, 8'h01, 8'h08);
    endtask

    task automatic t_leap();
        month_end("R7", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
        month_end("R7", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
        month_end("R7", 8'h29, 8'h02, 8'h24, 8'h01, 8'h03);
        month_end("R7", 8'h28, 8'h02, 8'h00, 8'h29, 8'h02);
        month_end("R7", 8'h28, 8'h02, 8'h10, 8'h01, 8'h03);
        month_end("R7", 8'h28, 8'h02, 8'h12, 8'h29, 8'h02);
    endtask

    task automatic t_halt();
        set_time(8'h29, 8'h59, 8'h05, 8'h01, 8'h01, 8'h01, 8'h20);
        wr(3'd0, 8'hB0);
        repeat (DIV * 5) @(negedge clk);
        expect_reg("R2", 3'd0, 8'hB0);
        expect_reg("R2", 3'd1, 8'h59);
        wr(3'd0, 8'h30);
        wait_secs(2);
        expect_reg("R2", 3'd0, 8'h32);
    endtask

    task automatic t_prescale_clear();
        set_time(8'h05, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h20);
        repeat (10) @(negedge clk);
        wr(3'd0, 8'h20);
        repeat (14) @(negedge clk);
        expect_reg("R10", 3'd0, 8'h20);
        repeat (6) @(negedge clk);
        expect_reg("R10", 3'd0, 8'h21);
    endtask

    task automatic t_map();
        wr(3'd0, 8'h80);
        wr(3'd1, 8'h42);
        wr(3'd2, 8'h92);
        wr(3'd3, 8'hF5);
        wr(3'd7, 8'hFF);
        expect_reg("R1", 3'd7, 8'h00);
        expect_reg("R1", 3'd1, 8'h42);
        expect_reg("R1", 3'd2, 8'h12);
        expect_reg("R1", 3'd3, 8'h05);
        expect_reg("R1", 3'd0, 8'h80);
    endtask

    task automatic t_write_abort();
        set_time(8'h59, 8'h59, 8'h03, 8'h01, 8'h01, 8'h01, 8'h20);
        repeat (17) @(negedge clk);
        wr(3'd2, 8'h05);
        repeat (4) @(negedge clk);
        expect_reg("R12", 3'd2, 8'h05);
        expect_reg("R12", 3'd1, 8'h00);
        expect_reg("R12", 3'd0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_count();
        t_full_rollover();
        t_24h_tens();
        t_12h();
        t_month_len();
        t_leap();
        t_halt();
        t_prescale_clear();
        t_write_abort();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule